// File: doc/BRIEF.md
# Answer-to-Reset Initial Character Analyzer

This block watches a smart-card interface while the card wakes up. It tracks the supply and card reset lines to decide when the interface is live. It counts rising edges of the card clock from the moment reset is released. It then takes the first character delivered by a separate character receiver and decides which coding convention the card uses. It also reports whether that character came too soon or never arrived within the allowed window.

Under the inverse convention, characters travel most-significant bit first and a high line level stands for logic zero. The convention flag from this block therefore tells the surrounding receiver how to reorder and invert every later character. The block does not parse later bytes, handle parity retries or sample the serial line itself.

Top module: `atr_ts_analyzer`

## Requirements
- R1: `active` is high one `clk` cycle after both `cardVcc` and `cardRstLine` are sampled high, and low one cycle after either is sampled low.
- R2: While `active` is high and no initial character has been taken, a one-cycle `rxDone` pulse captures `rxByte` and sets `tsSeen` on the next `clk` edge.
- R3: A captured value of 0x3B (direct convention) leaves `inverseConv` and `tsBad` at 0.
- R4: A captured value of 0x03 (an inverse-convention 0x3F as seen by a receiver running in direct mode) sets `inverseConv` to 1 and leaves `tsBad` at 0.
- R5: Any other captured value sets `tsBad` to 1 with `inverseConv` at 0.
- R6: After the first capture, further `rxDone` pulses do not change `tsSeen`, `tsBad`, `inverseConv`, `atrEarly` or `atrLate` while `active` stays high.
- R7: A card-clock rising edge is a `clk` edge at which `cardClk` is high after being low at the previous `clk` edge while `active` is high. `atrEarly` is set with the capture when fewer than `EARLY_CYC` (default 400) such edges were counted before it.
- R8: When `LATE_CYC` (default 40000) card-clock rising edges have been counted with no capture, `atrLate` is set on the next `clk` edge and stays set while `active` stays high; the edge counter saturates there.
- R9: When `active` is low, the edge counter and all flags clear on the next `clk` edge, whether the supply or the reset line dropped.
- R10: `rxDone` pulses while `active` is low are ignored.
- R11: An asynchronous low on `rstN` clears `active` and every flag, selecting the direct convention.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| cardVcc | input | 1 | Card supply present |
| cardRstLine | input | 1 | Card reset line, high means released |
| cardClk | input | 1 | Card clock, sampled by `clk` |
| rxDone | input | 1 | One-cycle end-of-character strobe from the receiver |
| rxByte | input | 8 | Character from the receiver, valid with `rxDone` |
| active | output | 1 | Interface activated |
| tsSeen | output | 1 | Initial character captured |
| tsBad | output | 1 | Initial character is neither convention code |
| inverseConv | output | 1 | Inverse convention detected |
| atrEarly | output | 1 | Initial character came before the early threshold |
| atrLate | output | 1 | Late threshold reached with no initial character |

## Verification
The bench places the character exactly one card-clock edge before and at the early threshold; an off-by-one compare would flag or miss early on the wrong side. It runs the count to one below and exactly at the late threshold, where a counter that saturates wrongly or compares with the wrong bound would set late a cycle off or never. It sends second characters of other values after a valid one and characters while the interface is down, which a design without proper latching or gating would capture. Supply loss and reset reassertion are each checked to clear every flag, which a design clearing on only one of them would miss.

// File: rtl/atr_ts_pkg.sv
package atr_ts_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;    // interface inactive: wipe counter and flags
    logic tick;     // one card-clock rising edge while waiting
    logic capture;  // take rxByte as the initial character
  } tsStrobe_t;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } tsState_t;

endpackage

// File: rtl/atr_ts_ctrl.sv
module atr_ts_ctrl
  import atr_ts_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cardVcc,
  input  logic      cardRstLine,
  input  logic      cardClk,
  input  logic      rxDone,
  output logic      activeO,
  output tsStrobe_t strobe
);

  logic     activeQ;
  logic     cardClkQ;
  logic     ckEdge;
  tsState_t stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ  <= 1'b0;
      cardClkQ <= 1'b0;
      stateQ   <= ST_OFF;
    end else begin
      activeQ  <= cardVcc & cardRstLine;
      cardClkQ <= cardClk;
      stateQ   <= stateD;
    end
  end

  assign ckEdge = cardClk & ~cardClkQ;

  always_comb begin
    stateD = stateQ;
    if (!activeQ) begin
      stateD = ST_OFF;
    end else begin
      case (stateQ)
        ST_OFF:  stateD = rxDone ? ST_DONE : ST_WAIT;
        ST_WAIT: if (rxDone) stateD = ST_DONE;
        default: stateD = ST_DONE;
      endcase
    end
  end

  always_comb begin
    strobe.clear   = ~activeQ;
    strobe.tick    = activeQ & ckEdge & (stateQ != ST_DONE);
    strobe.capture = activeQ & rxDone & (stateQ != ST_DONE);
  end

  assign activeO = activeQ;

endmodule

// File: rtl/atr_ts_dp.sv
module atr_ts_dp
  import atr_ts_pkg::*;
#(
  parameter int unsigned EARLY_CYC    = 400,
  parameter int unsigned LATE_CYC     = 40000,
  parameter logic [7:0]  DIRECT_CODE  = 8'h3B,
  parameter logic [7:0]  INVERSE_CODE = 8'h03
) (
  input  logic       clk,
  input  logic       rstN,
  input  tsStrobe_t  strobe,
  input  logic [7:0] rxByte,
  output logic       tsSeen,
  output logic       tsBad,
  output logic       inverseConv,
  output logic       atrEarly,
  output logic       atrLate
);

  localparam int unsigned CNT_W = $clog2(LATE_CYC + 1);
  localparam logic [CNT_W-1:0] EARLY_LIM = CNT_W'(EARLY_CYC);
  localparam logic [CNT_W-1:0] LATE_LIM  = CNT_W'(LATE_CYC);

  logic [CNT_W-1:0] cycCnt;
  logic             atLate;

  assign atLate = (cycCnt >= LATE_LIM);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycCnt      <= '0;
      tsSeen      <= 1'b0;
      tsBad       <= 1'b0;
      inverseConv <= 1'b0;
      atrEarly    <= 1'b0;
      atrLate     <= 1'b0;
    end else if (strobe.clear) begin
      cycCnt      <= '0;
      tsSeen      <= 1'b0;
      tsBad       <= 1'b0;
      inverseConv <= 1'b0;
      atrEarly    <= 1'b0;
      atrLate     <= 1'b0;
    end else begin
      if (strobe.tick && !atLate) cycCnt <= cycCnt + 1'b1;
      if (strobe.capture) begin
        tsSeen   <= 1'b1;
        atrEarly <= (cycCnt < EARLY_LIM);
        if (rxByte == DIRECT_CODE) begin
          inverseConv <= 1'b0;
          tsBad       <= 1'b0;
        end else if (rxByte == INVERSE_CODE) begin
          inverseConv <= 1'b1;
          tsBad       <= 1'b0;
        end else begin
          inverseConv <= 1'b0;
          tsBad       <= 1'b1;
        end
      end
      if (!tsSeen && !strobe.capture && atLate) atrLate <= 1'b1;
    end
  end

endmodule

// File: rtl/atr_ts_analyzer.sv
module atr_ts_analyzer
  import atr_ts_pkg::*;
#(
  parameter int unsigned EARLY_CYC = 400,
  parameter int unsigned LATE_CYC  = 40000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cardVcc,
  input  logic       cardRstLine,
  input  logic       cardClk,
  input  logic       rxDone,
  input  logic [7:0] rxByte,
  output logic       active,
  output logic       tsSeen,
  output logic       tsBad,
  output logic       inverseConv,
  output logic       atrEarly,
  output logic       atrLate
);

  tsStrobe_t strobe;

  atr_ts_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cardVcc     (cardVcc),
    .cardRstLine (cardRstLine),
    .cardClk     (cardClk),
    .rxDone      (rxDone),
    .activeO     (active),
    .strobe      (strobe)
  );

  atr_ts_dp #(
    .EARLY_CYC (EARLY_CYC),
    .LATE_CYC  (LATE_CYC)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .rxByte      (rxByte),
    .tsSeen      (tsSeen),
    .tsBad       (tsBad),
    .inverseConv (inverseConv),
    .atrEarly    (atrEarly),
    .atrLate     (atrLate)
  );

endmodule

// File: rtl/atr_ts_checker.sv
module atr_ts_checker (
  input logic clk,
  input logic rstN,
  input logic cardVcc,
  input logic cardRstLine,
  input logic rxDone,
  input logic active,
  input logic tsSeen,
  input logic tsBad,
  input logic inverseConv,
  input logic atrEarly,
  input logic atrLate
);

  assert_active_on_R1: assert property (@(posedge clk) disable iff (!rstN)
    (cardVcc && cardRstLine) |=> active);

  assert_active_off_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(cardVcc && cardRstLine) |=> !active);

  assert_capture_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tsSeen) |-> $past(rxDone));

  assert_conv_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    inverseConv |-> (tsSeen && !tsBad));

  assert_flags_latched_R6: assert property (@(posedge clk) disable iff (!rstN)
    (tsSeen && active) |=> (tsSeen && $stable(tsBad) && $stable(inverseConv) && $stable(atrEarly)));

  assert_early_needs_ts_R7: assert property (@(posedge clk) disable iff (!rstN)
    atrEarly |-> tsSeen);

  assert_late_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (atrLate && active) |=> atrLate);

  assert_clear_inactive_R9: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> (!tsSeen && !tsBad && !inverseConv && !atrEarly && !atrLate));

endmodule

bind atr_ts_analyzer atr_ts_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cardVcc     (cardVcc),
  .cardRstLine (cardRstLine),
  .rxDone      (rxDone),
  .active      (active),
  .tsSeen      (tsSeen),
  .tsBad       (tsBad),
  .inverseConv (inverseConv),
  .atrEarly    (atrEarly),
  .atrLate     (atrLate)
);

// File: tb/atr_ts_analyzer_bench.sv
`timescale 1ns/1ps
module atr_ts_analyzer_bench;

  localparam int EARLY_T = 40;
  localparam int LATE_T  = 300;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cardVcc = 1'b0;
  logic       cardRstLine = 1'b0;
  logic       cardClk = 1'b0;
  logic       rxDone = 1'b0;
  logic [7:0] rxByte = 8'h00;
  logic       active, tsSeen, tsBad, inverseConv, atrEarly, atrLate;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  atr_ts_analyzer #(.EARLY_CYC(EARLY_T), .LATE_CYC(LATE_T)) u_atr_ts_analyzer (
    .clk(clk), .rstN(rstN), .cardVcc(cardVcc), .cardRstLine(cardRstLine),
    .cardClk(cardClk), .rxDone(rxDone), .rxByte(rxByte), .active(active),
    .tsSeen(tsSeen), .tsBad(tsBad), .inverseConv(inverseConv),
    .atrEarly(atrEarly), .atrLate(atrLate)
  );

  function automatic logic expBad(input logic [7:0] b);
    return (b != 8'h3B) && (b != 8'h03);
  endfunction

  function automatic logic expInv(input logic [7:0] b);
    return b == 8'h03;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic activate();
    cardVcc = 1'b1;
    cardRstLine = 1'b1;
    step();
  endtask

  task automatic cardCycles(input int n);
    for (int i = 0; i < n; i++) begin
      cardClk = 1'b1; step();
      cardClk = 1'b0; step();
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    rxByte = b; rxDone = 1'b1; step();
    rxDone = 1'b0; rxByte = 8'h00; step();
  endtask

  task automatic deactivate(input bit bySupply);
    if (bySupply) cardVcc = 1'b0; else cardRstLine = 1'b0;
    step(); step();
    chk("R9 active", active, 0);
    chk("R9 flags", {tsSeen, tsBad, inverseConv, atrEarly, atrLate}, 0);
    cardVcc = 1'b0; cardRstLine = 1'b0;
    step();
  endtask

  task automatic runTs(input int n, input logic [7:0] b);
    activate();
    cardCycles(n);
    chk("R8 late before capture", atrLate, (n >= LATE_T));
    sendByte(b);
    chk("R2 tsSeen", tsSeen, 1);
    chk("R3/R5 tsBad", tsBad, expBad(b));
    chk("R4 inverseConv", inverseConv, expInv(b));
    chk("R7 early", atrEarly, (n < EARLY_T));
    chk("R8 late after capture", atrLate, (n >= LATE_T));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    step(); step();
    // R11: reset state
    chk("R11 outputs in reset", {active, tsSeen, tsBad, inverseConv, atrEarly, atrLate}, 0);
    rstN = 1'b1;
    step();

    // R1: supply alone does not activate
    cardVcc = 1'b1; step(); step();
    chk("R1 supply only", active, 0);
    // R10: character while inactive is ignored
    sendByte(8'h3B);
    chk("R10 ignored while inactive", tsSeen, 0);
    cardRstLine = 1'b1;
    chk("R1 before edge", active, 0);
    step();
    chk("R1 active", active, 1);
    deactivate(1'b0);

    // R3 direct, early boundary R7
    runTs(EARLY_T - 1, 8'h3B);
    chk("R7 one below threshold", atrEarly, 1);
    // R6: later bytes ignored
    sendByte(8'h03);
    chk("R6 inverse unchanged", inverseConv, 0);
    sendByte(8'h77);
    chk("R6 bad unchanged", tsBad, 0);
    chk("R6 early unchanged", atrEarly, 1);
    deactivate(1'b1);

    runTs(EARLY_T, 8'h03);
    chk("R7 at threshold", atrEarly, 0);
    chk("R4 inverse", inverseConv, 1);
    deactivate(1'b0);

    runTs(EARLY_T + 5, 8'hA5);
    chk("R5 error", tsBad, 1);
    deactivate(1'b1);

    // R8 late boundary
    activate();
    cardCycles(LATE_T - 1);
    chk("R8 one below late", atrLate, 0);
    cardCycles(1);
    chk("R8 at late", atrLate, 1);
    cardCycles(10);
    chk("R8 late sticky", atrLate, 1);
    sendByte(8'h3B);
    chk("R8 late after TS", atrLate, 1);
    chk("R2 captured after late", tsSeen, 1);
    chk("R7 not early", atrEarly, 0);
    deactivate(1'b0);

    // Random mix
    for (int k = 0; k < 24; k++) begin
      int n;
      int sel;
      logic [7:0] b;
      n = $urandom_range(0, LATE_T + 10);
      sel = $urandom_range(0, 2);
      b = (sel == 0) ? 8'h3B : (sel == 1) ? 8'h03 : 8'($urandom);
      runTs(n, b);
      deactivate(k[0]);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule